// File: doc/BRIEF.md
# Passive Matrix LCD Drive Timing Generator

This block produces the column-driver and row-driver control waveforms for a passive matrix LCD panel. Pixel data arrives as a stream of 4-bit nibbles on a valid/ready interface. Each accepted nibble is placed on the column data outputs with one shift-clock pulse. An enable-chain pulse advances the column-driver cascade after each group of sixteen nibbles. At the end of a line the block issues a line latch pulse. The same pulse clocks the row drivers. A scan-start level is raised for the whole of the last line of each frame.

The block also generates an AC-drive polarity signal that toggles either once per frame or once every programmable number of lines. It has a blanking output that is high while the panel is being driven. A sleep request takes effect at frame boundaries only, so the panel always blanks on a whole frame.

Configuration inputs set the number of nibbles per line, the number of lines per frame, the polarity mode and the line count used in line mode. Every generated clock is a one-cycle high pulse in the system clock domain, so its falling edge is the end of that cycle.

Top module: `lcd_drive_timing`

## Requirements
- R1: While rst_n is low, every output is low: xd, xscl, xecl, lp, yscl, yd, wf, ydis and pix_ready. ydis stays low after reset until the first frame boundary.
- R2: pix_ready is high only while a line is being filled and never in a cycle in which xscl is high. A nibble is accepted on a rising edge at which pix_valid and pix_ready are both high. The source must hold pix_valid and pix_data until that edge, and a stalled source simply stretches the line.
- R3: Each accepted nibble appears on xd in the next cycle, together with a one-cycle xscl pulse. xd holds that value through the following cycle. Nibbles leave in the order they were accepted. xscl never pulses without an accepted nibble, so it stays low while the source stalls.
- R4: xecl pulses together with the 16th, 32nd, and so on, xscl pulse of a line. The count restarts at every line.
- R5: After cfg_nibbles nibbles (cfg_nibbles ≥ 1), lp is high for exactly one cycle: the cycle right after the last xscl pulse of the line. xscl stays low from lp until the first nibble of the next line.
- R6: yscl pulses in exactly the same cycles as lp.
- R7: Lines are numbered 0 to cfg_lines−1 and then wrap (cfg_lines ≥ 2). yd is high for the whole of line cfg_lines−1 and low otherwise. yd changes only in the cycle after an lp pulse.
- R8: With cfg_wf_mode = 0, wf toggles in the cycle after the lp that ends the last line of a frame. With cfg_wf_mode = 1, wf toggles in the cycle after every cfg_wf_lines-th lp pulse (cfg_wf_lines ≥ 1), counted from reset. Frame boundaries then have no effect. wf changes at no other time.
- R9: A frame boundary is the lp that ends line cfg_lines−1. At each boundary, sleep_req is sampled, and ydis takes the inverse of the value sampled at the previous boundary (treated as 0 at the first boundary). ydis therefore falls one to two frames after a request and changes only in the cycle after an lp pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_nibbles | input | NIB_W | Nibbles per display line (≥ 1) |
| cfg_lines | input | LINE_W | Lines per frame (≥ 2) |
| cfg_wf_mode | input | 1 | 0: wf toggles per frame; 1: wf toggles every cfg_wf_lines lines |
| cfg_wf_lines | input | LINE_W | Line count between wf toggles in line mode (≥ 1) |
| sleep_req | input | 1 | Request to blank the panel, sampled at frame boundaries |
| pix_valid | input | 1 | Source has a nibble on pix_data |
| pix_data | input | 4 | Pixel nibble |
| pix_ready | output | 1 | Block accepts a nibble on this edge |
| xd | output | 4 | Column driver data |
| xscl | output | 1 | Column data shift clock, one-cycle pulse |
| xecl | output | 1 | Column driver enable-chain clock, one-cycle pulse |
| lp | output | 1 | Line latch pulse |
| yscl | output | 1 | Row driver shift clock |
| yd | output | 1 | Row scan start level |
| wf | output | 1 | AC drive polarity |
| ydis | output | 1 | High while the panel is driven |

## Verification
xd, xscl and xecl are due one cycle after the edge that accepts a nibble. lp and yscl are due one cycle after the last xscl of the line. yd, wf and ydis change one cycle after lp. The bench samples every output at the falling clock edge and drives inputs just after the rising edge, so each value is read in the cycle it is due. Its reference model updates the expected row level, polarity and blanking state only after it has compared the lp cycle itself. Handshakes are recorded at the falling edge before the accepting rising edge, so each xscl pulse is matched to the nibble taken one cycle earlier.

// File: rtl/lcdt_pkg.sv
package lcdt_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE,
    SEQ_SHIFT,
    SEQ_LATCH,
    SEQ_EOL
  } seq_state_e;
endpackage

// File: rtl/lcdt_xshift.sv
module lcdt_xshift #(
  parameter int NIB_W     = 8,
  parameter int CHAIN_LEN = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_open,
  input  logic [NIB_W-1:0] cfg_nibbles,
  input  logic             pix_valid,
  input  logic [3:0]       pix_data,
  output logic             pix_ready,
  output logic [3:0]       xd,
  output logic             xscl,
  output logic             xecl,
  output logic             last_acc
);
  localparam int CH_W = (CHAIN_LEN > 1) ? $clog2(CHAIN_LEN) : 1;
  localparam logic [CH_W-1:0] CH_LAST = CH_W'(CHAIN_LEN - 1);

  logic [NIB_W-1:0] nib_cnt;
  logic [CH_W-1:0]  chain_cnt;
  logic             acc;
  logic             chain_end;

  // one free cycle after each shift pulse gives xscl a falling edge
  assign pix_ready = line_open & ~xscl;
  assign acc       = pix_valid & pix_ready;
  assign last_acc  = acc && (nib_cnt == (cfg_nibbles - NIB_W'(1)));
  assign chain_end = (chain_cnt == CH_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xd        <= '0;
      xscl      <= 1'b0;
      xecl      <= 1'b0;
      nib_cnt   <= '0;
      chain_cnt <= '0;
    end else begin
      xscl <= acc;
      xecl <= acc & chain_end;
      if (acc) begin
        xd <= pix_data;
        if (last_acc) begin
          nib_cnt   <= '0;
          chain_cnt <= '0;
        end else begin
          nib_cnt   <= nib_cnt + NIB_W'(1);
          chain_cnt <= chain_end ? '0 : chain_cnt + CH_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/lcdt_lineseq.sv
module lcdt_lineseq
  import lcdt_pkg::*;
#(
  parameter int LINE_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              last_acc,
  input  logic [LINE_W-1:0] cfg_lines,
  output logic              line_open,
  output logic              lp,
  output logic              yscl,
  output logic              yd,
  output logic              line_end,
  output logic              frame_end
);
  seq_state_e        state;
  logic [LINE_W-1:0] line_idx;
  logic [LINE_W-1:0] line_nxt;
  logic [LINE_W-1:0] last_line;

  assign last_line = cfg_lines - LINE_W'(1);
  assign line_open = (state == SEQ_SHIFT);
  assign line_end  = (state == SEQ_EOL);
  assign frame_end = line_end && (line_idx == last_line);
  assign line_nxt  = frame_end ? '0 : line_idx + LINE_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= SEQ_IDLE;
      line_idx <= '0;
      lp       <= 1'b0;
      yscl     <= 1'b0;
      yd       <= 1'b0;
    end else begin
      case (state)
        SEQ_IDLE:  state <= SEQ_SHIFT;
        SEQ_SHIFT: if (last_acc) state <= SEQ_LATCH;
        SEQ_LATCH: begin
          lp    <= 1'b1;
          yscl  <= 1'b1;
          state <= SEQ_EOL;
        end
        SEQ_EOL: begin
          lp       <= 1'b0;
          yscl     <= 1'b0;
          line_idx <= line_nxt;
          yd       <= (line_nxt == last_line);
          state    <= SEQ_SHIFT;
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/lcdt_framectl.sv
module lcdt_framectl #(
  parameter int LINE_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_end,
  input  logic              frame_end,
  input  logic              cfg_wf_mode,
  input  logic [LINE_W-1:0] cfg_wf_lines,
  input  logic              sleep_req,
  output logic              wf,
  output logic              ydis
);
  logic [LINE_W-1:0] wf_cnt;
  logic              sleep_pend;
  logic              wf_line_hit;

  assign wf_line_hit = (wf_cnt == (cfg_wf_lines - LINE_W'(1)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wf         <= 1'b0;
      wf_cnt     <= '0;
      ydis       <= 1'b0;
      sleep_pend <= 1'b0;
    end else begin
      if (line_end) begin
        if (cfg_wf_mode) begin
          if (wf_line_hit) begin
            wf     <= ~wf;
            wf_cnt <= '0;
          end else begin
            wf_cnt <= wf_cnt + LINE_W'(1);
          end
        end else begin
          wf_cnt <= '0;
          if (frame_end) wf <= ~wf;
        end
      end
      if (frame_end) begin
        ydis       <= ~sleep_pend;
        sleep_pend <= sleep_req;
      end
    end
  end
endmodule

// File: rtl/lcd_drive_timing.sv
module lcd_drive_timing #(
  parameter int NIB_W     = 8,
  parameter int LINE_W    = 9,
  parameter int CHAIN_LEN = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NIB_W-1:0]  cfg_nibbles,
  input  logic [LINE_W-1:0] cfg_lines,
  input  logic              cfg_wf_mode,
  input  logic [LINE_W-1:0] cfg_wf_lines,
  input  logic              sleep_req,
  input  logic              pix_valid,
  input  logic [3:0]        pix_data,
  output logic              pix_ready,
  output logic [3:0]        xd,
  output logic              xscl,
  output logic              xecl,
  output logic              lp,
  output logic              yscl,
  output logic              yd,
  output logic              wf,
  output logic              ydis
);
  logic line_open;
  logic last_acc;
  logic line_end;
  logic frame_end;

  lcdt_xshift #(.NIB_W(NIB_W), .CHAIN_LEN(CHAIN_LEN)) u_xshift (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_open  (line_open),
    .cfg_nibbles(cfg_nibbles),
    .pix_valid  (pix_valid),
    .pix_data   (pix_data),
    .pix_ready  (pix_ready),
    .xd         (xd),
    .xscl       (xscl),
    .xecl       (xecl),
    .last_acc   (last_acc)
  );

  lcdt_lineseq #(.LINE_W(LINE_W)) u_lineseq (
    .clk      (clk),
    .rst_n    (rst_n),
    .last_acc (last_acc),
    .cfg_lines(cfg_lines),
    .line_open(line_open),
    .lp       (lp),
    .yscl     (yscl),
    .yd       (yd),
    .line_end (line_end),
    .frame_end(frame_end)
  );

  lcdt_framectl #(.LINE_W(LINE_W)) u_framectl (
    .clk         (clk),
    .rst_n       (rst_n),
    .line_end    (line_end),
    .frame_end   (frame_end),
    .cfg_wf_mode (cfg_wf_mode),
    .cfg_wf_lines(cfg_wf_lines),
    .sleep_req   (sleep_req),
    .wf          (wf),
    .ydis        (ydis)
  );
endmodule

// File: rtl/lcdt_checker.sv
module lcdt_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       pix_valid,
  input logic       pix_ready,
  input logic [3:0] xd,
  input logic       xscl,
  input logic       xecl,
  input logic       lp,
  input logic       yscl,
  input logic       yd,
  input logic       wf,
  input logic       ydis
);
  assert_ready_off_in_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    xscl |-> !pix_ready);

  assert_pulse_needs_accept_R3: assert property (@(posedge clk) disable iff (!rst_n)
    xscl |-> $past(pix_valid && pix_ready));

  assert_xd_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    xscl |=> $stable(xd));

  assert_chain_with_shift_R4: assert property (@(posedge clk) disable iff (!rst_n)
    xecl |-> xscl);

  assert_shift_halted_at_latch_R5: assert property (@(posedge clk) disable iff (!rst_n)
    lp |-> !xscl);

  assert_latch_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    lp |=> !lp);

  assert_row_clk_with_latch_R6: assert property (@(posedge clk) disable iff (!rst_n)
    lp |-> yscl);

  assert_row_clk_only_latch_R6: assert property (@(posedge clk) disable iff (!rst_n)
    yscl |-> lp);

  assert_scan_moves_after_lp_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(yd) || $fell(yd)) |-> $past(lp));

  assert_wf_moves_after_lp_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(wf) || $fell(wf)) |-> $past(lp));

  assert_blank_moves_after_lp_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ydis) || $fell(ydis)) |-> $past(lp));
endmodule

bind lcd_drive_timing lcdt_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .pix_valid(pix_valid),
  .pix_ready(pix_ready),
  .xd       (xd),
  .xscl     (xscl),
  .xecl     (xecl),
  .lp       (lp),
  .yscl     (yscl),
  .yd       (yd),
  .wf       (wf),
  .ydis     (ydis)
);

// File: tb/sim_lcd_drive_timing.sv
module sim_lcd_drive_timing;
  localparam int NIB   = 20;
  localparam int LINES = 4;
  localparam int NSTIM = 24;
  // {gap cycles before valid, nibble}
  localparam logic [7:0] STIM [0:NSTIM-1] = '{
    8'h03, 8'h0A, 8'h2F, 8'h00, 8'h15, 8'h06, 8'h3C, 8'h09,
    8'h0E, 8'h11, 8'h07, 8'h0B, 8'h24, 8'h0D, 8'h02, 8'h38,
    8'h0F, 8'h01, 8'h1C, 8'h05, 8'h08, 8'h3E, 8'h04, 8'h0A
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] cfg_nibbles = 8'(NIB);
  logic [8:0] cfg_lines = 9'(LINES);
  logic       cfg_wf_mode = 1'b0;
  logic [8:0] cfg_wf_lines = 9'd3;
  logic       sleep_req = 1'b0;
  logic       pix_valid = 1'b0;
  logic [3:0] pix_data = 4'h0;
  logic       pix_ready, xscl, xecl, lp, yscl, yd, wf, ydis;
  logic [3:0] xd;

  int  tests = 0;
  int  fails = 0;
  bit  done = 1'b0;
  bit  first_run = 1'b1;
  int  lp_count = 0;
  int  cap_idx = 0;
  int  nib_line = 0;
  int  line_m = 0;
  int  wf_cnt_m = 0;
  bit  wf_exp = 1'b0;
  bit  ydis_exp = 1'b0;
  bit  pend_m = 1'b0;
  bit  hs_prev = 1'b0;
  logic [3:0] hs_data = 4'h0;
  bit  prev_xscl = 1'b0;
  bit  prev_lp = 1'b0;

  always #4 clk = ~clk;

  lcd_drive_timing u0 (
    .clk(clk), .rst_n(rst_n), .cfg_nibbles(cfg_nibbles), .cfg_lines(cfg_lines),
    .cfg_wf_mode(cfg_wf_mode), .cfg_wf_lines(cfg_wf_lines), .sleep_req(sleep_req),
    .pix_valid(pix_valid), .pix_data(pix_data), .pix_ready(pix_ready),
    .xd(xd), .xscl(xscl), .xecl(xecl), .lp(lp), .yscl(yscl), .yd(yd),
    .wf(wf), .ydis(ydis)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic send(input logic [3:0] d, input int gap);
    for (int g = 0; g < gap; g++) begin
      pix_valid = 1'b0;
      @(posedge clk); #1;
    end
    pix_valid = 1'b1;
    pix_data  = d;
    @(negedge clk);
    while (!pix_ready) @(negedge clk);
    @(posedge clk); #1;
    pix_valid = 1'b0;
  endtask

  task automatic wait_lines(input int n);
    while (lp_count < n) @(negedge clk);
    @(negedge clk);
  endtask

  // reference model and continuous port checks
  always @(negedge clk) begin
    if (!rst_n) begin
      chk({xd, xscl, xecl, lp, yscl, yd, wf, ydis, pix_ready} == '0,
          "R1 outputs low in reset", {xd, xscl, xecl, lp, yscl, yd, wf, ydis, pix_ready}, 0);
      lp_count = 0; nib_line = 0; line_m = 0; wf_cnt_m = 0;
      wf_exp = 1'b0; ydis_exp = 1'b0; pend_m = 1'b0;
      hs_prev = 1'b0; prev_xscl = 1'b0; prev_lp = 1'b0;
    end else begin
      if (xscl) begin
        chk(hs_prev, "R3 xscl follows an accepted nibble", 0, 1);
        chk(xd == hs_data, "R3 xd carries accepted nibble", xd, hs_data);
        chk(!pix_ready, "R2 ready low during xscl", pix_ready, 0);
        if (first_run && cap_idx < NSTIM)
          chk(xd == STIM[cap_idx][3:0], "R3 nibble order", xd, STIM[cap_idx][3:0]);
        cap_idx++;
        nib_line++;
        chk(xecl == ((nib_line % 16) == 0), "R4 xecl on 16th shift", xecl, (nib_line % 16) == 0);
      end else if (xecl) begin
        chk(1'b0, "R4 xecl without xscl", 1, 0);
      end
      chk(yscl == lp, "R6 yscl matches lp", yscl, lp);
      chk(yd == (line_m == LINES - 1), "R7 yd on last line", yd, line_m == LINES - 1);
      chk(wf == wf_exp, "R8 wf polarity", wf, wf_exp);
      chk(ydis == ydis_exp, "R9 ydis state", ydis, ydis_exp);
      if (lp) begin
        chk(!xscl && prev_xscl, "R5 lp right after last xscl", prev_xscl, 1);
        chk(nib_line == NIB, "R5 xscl pulses per line", nib_line, NIB);
        chk(!prev_lp, "R5 lp one cycle", prev_lp, 0);
        nib_line = 0;
        if (cfg_wf_mode) begin
          if (wf_cnt_m == int'(cfg_wf_lines) - 1) begin
            wf_exp = ~wf_exp; wf_cnt_m = 0;
          end else wf_cnt_m++;
        end
        if (line_m == LINES - 1) begin
          if (!cfg_wf_mode) wf_exp = ~wf_exp;
          ydis_exp = ~pend_m;
          pend_m = sleep_req;
          line_m = 0;
        end else line_m++;
        lp_count++;
      end
      hs_prev   = pix_valid && pix_ready;
      hs_data   = pix_data;
      prev_xscl = xscl;
      prev_lp   = lp;
    end
  end

  // pixel source: stimulus table, then generated filler with stalls
  initial begin
    @(posedge clk); #1;
    while (!rst_n) begin @(posedge clk); #1; end
    for (int i = 0; i < NSTIM; i++) send(STIM[i][3:0], int'(STIM[i][7:4]));
    for (int k = 0; k < 100000; k++) send(4'(k ^ 5), ((k % 7) == 3) ? 2 : 0);
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog all requirements actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(ydis == 1'b0 && pix_ready == 1'b0 && lp == 1'b0, "R1 reset state", {ydis, pix_ready, lp}, 0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    @(negedge clk);
    chk(pix_ready == 1'b0, "R2 ready low on first cycle after reset", pix_ready, 0);

    wait_lines(2);
    chk(ydis == 1'b0, "R9 ydis low before first boundary", ydis, 0);
    wait_lines(4);
    chk(ydis == 1'b1, "R9 ydis high after first boundary", ydis, 1);
    chk(wf == 1'b1, "R8 wf toggled at first frame end", wf, 1);
    wait_lines(12);

    @(posedge clk); #1;
    sleep_req = 1'b1;
    wait_lines(16);
    chk(ydis == 1'b1, "R9 ydis still high one boundary after request", ydis, 1);
    wait_lines(20);
    chk(ydis == 1'b0, "R9 ydis low at next boundary", ydis, 0);
    @(posedge clk); #1;
    sleep_req = 1'b0;
    wait_lines(24);
    chk(ydis == 1'b0, "R9 ydis stays low one boundary after wake", ydis, 0);
    wait_lines(28);
    chk(ydis == 1'b1, "R9 ydis back high", ydis, 1);

    @(posedge clk); #1;
    rst_n = 1'b0;
    first_run = 1'b0;
    cfg_wf_mode = 1'b1;
    cfg_wf_lines = 9'd3;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    wait_lines(3);
    chk(wf == 1'b1, "R8 line mode toggle after 3 lines", wf, 1);
    wait_lines(4);
    chk(wf == 1'b1, "R8 frame end ignored in line mode", wf, 1);
    wait_lines(6);
    chk(wf == 1'b0, "R8 line mode second toggle", wf, 0);
    wait_lines(10);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule